// File: doc/BRIEF.md
# Injected Conversion Context Queue

This block holds the sequence contexts for injected conversions of an analog converter in a queue that is two entries deep. Software pushes a context word through a write port at any time, including while a sequence is running. The block always presents the active context on a read port. Each context word carries a sequence length of one to four conversions and four channel numbers. For every accepted hardware trigger, the block issues a conversion request that names a channel. It then walks through the sequence positions, using the converter's done pulse to advance.

When a sequence ends, the active context is consumed and the next queued one takes over. A queue-mode input selects the behaviour when the queue runs dry:
- **Mode 0** keeps the last context and reuses it for later sequences.
- **Mode 1** lets the queue empty. Triggers are then blocked until a new context is written.

A stop request or a disable request flushes the queue. A write into a full queue is dropped and raises a sticky overflow flag, which can also drive an interrupt. In discontinuous mode, each trigger performs a single conversion of the sequence.

Top module: `injctx_ctrl`

## Requirements
- R1: The queue holds at most two contexts. A write while two are held leaves both stored contexts, and the order in which they are used, unchanged.
- R2: A write to an empty queue is shown on `rd_ctx` in the next cycle. A trigger presented from that cycle on is accepted.
- R3: When the last conversion of a sequence completes, the active context is consumed and the next queued context appears on `rd_ctx` in the following cycle.
- R4: A dropped write sets `ovf_flag`, which then stays set until `ovf_clr` is high in a cycle with no new dropped write. If a dropped write and `ovf_clr` occur in the same cycle, the flag stays set. `irq` equals `ovf_flag` AND `ovf_ie`.
- R5: `rd_ctx` returns the active context, or zero when no context is held. After reset, the queue is empty, `ovf_flag` is 0 and `conv_req` is 0.
- R6: With `qmode`=0, a context that finishes a sequence while it is the only one held stays active and serves every later sequence.
- R7: With `qmode`=1, the queue empties after its last context is used. While the queue is empty, triggers cause no conversion request.
- R8: A high `stop_req` or `dis_req` aborts any running sequence and resets the position to 0. With `qmode`=0 it keeps only the active context. With `qmode`=1 it empties the queue.
- R9: In a context word, bits [1:0] hold the number of conversions minus one. Channel k is held at bits [2+5k +: 5]. Conversions run from k=0 upward. `conv_req` pulses for one cycle, in the cycle after the trigger or done pulse that causes it, with `conv_ch` set to the channel and `seq_pos` equal to k.
- R10: With `disc`=0, one trigger runs the whole sequence. Each next request follows a done pulse by one cycle. Triggers during a running sequence are ignored.
- R11: With `disc`=1, each trigger performs exactly one conversion. After a done pulse that is not the last of the sequence, no request follows and `seq_pos` advances by one.
- R12: If a write and a consume fall in the same cycle, the consume takes effect first. A write to a queue that was full before the consume is therefore stored and not flagged as an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Context write strobe |
| wr_ctx | input | 22 | Context word to push |
| rd_ctx | output | 22 | Active context, or zero when none is held |
| trig | input | 1 | Hardware trigger pulse |
| conv_done | input | 1 | Converter done pulse |
| stop_req | input | 1 | Stop injected conversions; flushes the queue |
| dis_req | input | 1 | Disable converter; flushes the queue |
| qmode | input | 1 | 0: retain the last context, 1: allow the queue to empty |
| disc | input | 1 | Discontinuous mode: one conversion per trigger |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_ie | input | 1 | Overflow interrupt enable |
| conv_req | output | 1 | Conversion request pulse |
| conv_ch | output | 5 | Channel of the request |
| seq_pos | output | 2 | Current position in the sequence |
| conv_busy | output | 1 | A conversion is outstanding |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt |

## Verification
The bench sweeps every sequence length against several channel patterns, in both trigger modes. A mis-sliced channel field or an off-by-one length would show up there as a wrong `conv_ch` or a missing request. It fills the queue and writes once more to confirm that the third context never runs. It also writes in the same cycle as the consuming done pulse, where a design that checks fullness before the consume would raise a false overflow. Flushes are applied in both queue modes and in the middle of a sequence: a design that forgets to abort would keep issuing requests, and one that empties in mode 0 would lose its retained context.

// File: rtl/injctx_pkg.sv
package injctx_pkg;
  localparam int CH_W   = 5;
  localparam int NSLOT  = 4;
  localparam int LEN_W  = $clog2(NSLOT);
  localparam int CTX_W  = LEN_W + NSLOT * CH_W;
  localparam int QDEPTH = 2;

  typedef logic [CTX_W-1:0] ctx_t;

  // index of the last conversion in the sequence
  function automatic logic [LEN_W-1:0] ctx_last(ctx_t c);
    return c[LEN_W-1:0];
  endfunction

  // channel held in slot k
  function automatic logic [CH_W-1:0] ctx_chan(ctx_t c, logic [LEN_W-1:0] k);
    return c[LEN_W + int'(k) * CH_W +: CH_W];
  endfunction
endpackage

// File: rtl/injctx_store.sv
module injctx_store
  import injctx_pkg::*;
#(
  parameter int DEPTH = QDEPTH,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  ctx_t             wr_ctx,
  input  logic             consume,
  input  logic             flush,
  input  logic             qmode,
  output ctx_t             act_ctx,
  output logic             act_valid,
  output logic [CNT_W-1:0] count,
  output logic             push_ok,
  output logic             ovf_evt
);
  ctx_t             q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_mid;
  logic             pop;

  // consume and flush are resolved before the write is judged
  always_comb begin
    cnt_mid = cnt_q;
    pop     = 1'b0;
    if (flush) begin
      cnt_mid = (qmode || cnt_q == '0) ? '0 : CNT_W'(1);
    end else if (consume && cnt_q != '0) begin
      if (qmode || cnt_q > CNT_W'(1)) begin
        pop     = 1'b1;
        cnt_mid = cnt_q - CNT_W'(1);
      end
    end
    push_ok = wr_en && (cnt_mid < CNT_W'(DEPTH));
    ovf_evt = wr_en && !push_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_mid + CNT_W'(push_ok);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[i] <= '0;
      end else if (push_ok && cnt_mid == CNT_W'(i)) begin
        q[i] <= wr_ctx;
      end else if (pop && i < DEPTH - 1) begin
        q[i] <= q[(i < DEPTH - 1) ? i + 1 : i];
      end
    end
  end

  assign act_valid = (cnt_q != '0);
  assign act_ctx   = act_valid ? q[0] : '0;
  assign count     = cnt_q;
endmodule

// File: rtl/injctx_seq.sv
module injctx_seq
  import injctx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ctx_t             ctx,
  input  logic             ctx_valid,
  input  logic             trig,
  input  logic             conv_done,
  input  logic             abort,
  input  logic             disc,
  output logic             trig_acc,
  output logic             done_acc,
  output logic             seq_end,
  output logic             req,
  output logic [CH_W-1:0]  ch,
  output logic [LEN_W-1:0] pos,
  output logic             busy
);
  logic [LEN_W-1:0] pos_q, pos_nx;
  logic             busy_q, req_q, last_hit;
  logic [CH_W-1:0]  ch_q;

  assign pos_nx   = pos_q + 1'b1;
  assign last_hit = (pos_q == ctx_last(ctx));
  assign trig_acc = trig && ctx_valid && !busy_q && !abort;
  assign done_acc = conv_done && busy_q && !abort;
  assign seq_end  = done_acc && last_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      busy_q <= 1'b0;
      req_q  <= 1'b0;
      ch_q   <= '0;
    end else begin
      req_q <= 1'b0;
      if (abort) begin
        busy_q <= 1'b0;
        pos_q  <= '0;
      end else if (trig_acc) begin
        busy_q <= 1'b1;
        req_q  <= 1'b1;
        ch_q   <= ctx_chan(ctx, pos_q);
      end else if (done_acc) begin
        if (last_hit) begin
          busy_q <= 1'b0;
          pos_q  <= '0;
        end else begin
          pos_q <= pos_nx;
          if (disc) begin
            busy_q <= 1'b0;
          end else begin
            req_q <= 1'b1;
            ch_q  <= ctx_chan(ctx, pos_nx);
          end
        end
      end
    end
  end

  assign req  = req_q;
  assign ch   = ch_q;
  assign pos  = pos_q;
  assign busy = busy_q;
endmodule

// File: rtl/injctx_ovf.sv
module injctx_ovf (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_evt,
  input  logic clr,
  input  logic ie,
  output logic flag,
  output logic irq
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (ovf_evt) flag_q <= 1'b1;
    else if (clr)     flag_q <= 1'b0;
  end

  assign flag = flag_q;
  assign irq  = flag_q & ie;
endmodule

// File: rtl/injctx_ctrl.sv
module injctx_ctrl
  import injctx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTX_W-1:0] wr_ctx,
  output logic [CTX_W-1:0] rd_ctx,
  input  logic             trig,
  input  logic             conv_done,
  input  logic             stop_req,
  input  logic             dis_req,
  input  logic             qmode,
  input  logic             disc,
  input  logic             ovf_clr,
  input  logic             ovf_ie,
  output logic             conv_req,
  output logic [CH_W-1:0]  conv_ch,
  output logic [LEN_W-1:0] seq_pos,
  output logic             conv_busy,
  output logic             ovf_flag,
  output logic             irq
);
  localparam int CNT_W = $clog2(QDEPTH + 1);

  // named internal events, observed by the checker
  logic             flush, seq_end, trig_acc, done_acc;
  logic             push_ok, ovf_evt, act_valid;
  logic [CNT_W-1:0] q_count;
  ctx_t             act_ctx;

  assign flush = stop_req | dis_req;

  injctx_store #(.DEPTH(QDEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ctx(wr_ctx),
    .consume(seq_end), .flush(flush), .qmode(qmode),
    .act_ctx(act_ctx), .act_valid(act_valid), .count(q_count),
    .push_ok(push_ok), .ovf_evt(ovf_evt)
  );

  injctx_seq u_seq (
    .clk(clk), .rst_n(rst_n), .ctx(act_ctx), .ctx_valid(act_valid),
    .trig(trig), .conv_done(conv_done), .abort(flush), .disc(disc),
    .trig_acc(trig_acc), .done_acc(done_acc), .seq_end(seq_end),
    .req(conv_req), .ch(conv_ch), .pos(seq_pos), .busy(conv_busy)
  );

  injctx_ovf u_ovf (
    .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .clr(ovf_clr),
    .ie(ovf_ie), .flag(ovf_flag), .irq(irq)
  );

  assign rd_ctx = act_ctx;
endmodule

// File: rtl/injctx_checker.sv
module injctx_checker
  import injctx_pkg::*;
#(
  localparam int CNT_W = $clog2(QDEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] q_count,
  input logic [CTX_W-1:0] rd_ctx,
  input logic             trig_acc,
  input logic             done_acc,
  input logic             seq_end,
  input logic             flush,
  input logic             qmode,
  input logic             ovf_evt,
  input logic             ovf_clr,
  input logic             ovf_flag,
  input logic             conv_req,
  input logic             conv_busy,
  input logic [LEN_W-1:0] seq_pos
);
  p_ovf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag);

  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  p_empty_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count == '0) |-> (rd_ctx == '0));

  p_no_trig_when_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count == '0) |-> !trig_acc);

  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && qmode) |=> (q_count == '0));

  p_flush_keeps_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !qmode && q_count != '0) |=> (q_count != '0 && $stable(rd_ctx)));

  p_retain_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_end && !qmode && !flush && q_count == CNT_W'(1)) |=> (q_count != '0 && $stable(rd_ctx)));

  p_req_has_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> $past(trig_acc || done_acc));

  p_pos_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count != '0) |-> (seq_pos <= rd_ctx[LEN_W-1:0]));

  p_busy_blocks_trig_r10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy |-> !trig_acc);

  p_done_only_when_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_acc |-> conv_busy);
endmodule

bind injctx_ctrl injctx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .q_count(q_count), .rd_ctx(rd_ctx),
  .trig_acc(trig_acc), .done_acc(done_acc), .seq_end(seq_end),
  .flush(flush), .qmode(qmode), .ovf_evt(ovf_evt), .ovf_clr(ovf_clr),
  .ovf_flag(ovf_flag), .conv_req(conv_req), .conv_busy(conv_busy),
  .seq_pos(seq_pos)
);

// File: tb/injctx_ctrl_bench.sv
module injctx_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 0, trig = 0, conv_done = 0, stop_req = 0, dis_req = 0;
  logic        qmode = 0, disc = 0, ovf_clr = 0, ovf_ie = 0;
  logic [21:0] wr_ctx = '0;
  logic [21:0] rd_ctx;
  logic        conv_req, conv_busy, ovf_flag, irq;
  logic [4:0]  conv_ch;
  logic [1:0]  seq_pos;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  injctx_ctrl u_injctx_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ctx(wr_ctx), .rd_ctx(rd_ctx),
    .trig(trig), .conv_done(conv_done), .stop_req(stop_req), .dis_req(dis_req),
    .qmode(qmode), .disc(disc), .ovf_clr(ovf_clr), .ovf_ie(ovf_ie),
    .conv_req(conv_req), .conv_ch(conv_ch), .seq_pos(seq_pos),
    .conv_busy(conv_busy), .ovf_flag(ovf_flag), .irq(irq)
  );

  // context word built arithmetically: count-1 in the low two bits, channel k at 2+5k
  function automatic int mk(int last, int c0, int c1, int c2, int c3);
    return last + c0 * 4 + c1 * 128 + c2 * 4096 + c3 * 131072;
  endfunction

  function automatic int expch(int ctx, int k);
    return (ctx / (4 * (32 ** k))) % 32;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(int w);
    wr_en = 1; wr_ctx = w[21:0];
    step();
    wr_en = 0;
  endtask

  task automatic pulse_trig();
    trig = 1; step(); trig = 0;
  endtask

  task automatic pulse_done();
    conv_done = 1; step(); conv_done = 0;
  endtask

  task automatic run_seq(int ctx, bit d);
    int n = ctx % 4 + 1;
    disc = d;
    for (int i = 0; i < n; i++) begin
      if (d || i == 0) pulse_trig();
      chk(d ? "R11 request per trigger" : "R10 request issued", int'(conv_req), 1);
      chk("R9 channel order", int'(conv_ch), expch(ctx, i));
      chk("R9 position", int'(seq_pos), i);
      pulse_done();
      if (d && i < n - 1) begin
        chk("R11 no request between triggers", int'(conv_req), 0);
        chk("R11 position advance", int'(seq_pos), i + 1);
      end
    end
    chk("R10 no request after last", int'(conv_req), 0);
    chk("R9 position back to 0", int'(seq_pos), 0);
    disc = 0;
  endtask

  initial begin
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int a, b, c;
    repeat (3) step();
    rst_n = 1;
    step();
    // R5 reset state
    chk("R5 reset rd_ctx", int'(rd_ctx), 0);
    chk("R5 reset conv_req", int'(conv_req), 0);
    chk("R5 reset ovf_flag", int'(ovf_flag), 0);
    chk("R5 reset irq", int'(irq), 0);

    // R7: triggers on an empty queue
    qmode = 1;
    pulse_trig();
    chk("R7 trigger ignored when empty", int'(conv_req), 0);

    // R2/R3/R7/R9/R10/R11 sweep: every length, several patterns, both trigger modes
    for (int d = 0; d < 2; d++)
      for (int l = 0; l < 4; l++)
        for (int p = 0; p < 4; p++) begin
          a = mk(l, (p * 7 + 1) % 32, (p * 11 + 30) % 32, (p * 5 + 17) % 32, 31 - p);
          wr(a);
          chk("R2 write visible", int'(rd_ctx), a);
          run_seq(a, d[0]);
          chk("R7 empty after sequence", int'(rd_ctx), 0);
          pulse_trig();
          chk("R7 trigger ignored after drain", int'(conv_req), 0);
        end

    // R10: trigger during running sequence ignored
    a = mk(1, 3, 9, 0, 0);
    wr(a);
    pulse_trig();
    chk("R10 first request", int'(conv_req), 1);
    pulse_trig();
    chk("R10 mid-sequence trigger ignored", int'(conv_req), 0);
    chk("R10 position held", int'(seq_pos), 0);
    pulse_done();
    chk("R10 second request", int'(conv_req), 1);
    chk("R10 second channel", int'(conv_ch), 9);
    pulse_done();
    chk("R3 drained", int'(rd_ctx), 0);

    // R1/R4 overflow
    ovf_ie = 1;
    a = mk(0, 4, 0, 0, 0); b = mk(1, 5, 6, 0, 0); c = mk(0, 7, 0, 0, 0);
    wr(a); wr(b);
    chk("R4 no overflow yet", int'(ovf_flag), 0);
    wr(c);
    chk("R4 overflow flag", int'(ovf_flag), 1);
    chk("R4 irq", int'(irq), 1);
    chk("R1 active unchanged", int'(rd_ctx), a);
    ovf_ie = 0;
    step();
    chk("R4 irq masked", int'(irq), 0);
    chk("R4 flag sticky", int'(ovf_flag), 1);
    ovf_clr = 1; wr(c); ovf_clr = 0;
    chk("R4 set wins over clear", int'(ovf_flag), 1);
    run_seq(a, 0);
    chk("R3 next context active", int'(rd_ctx), b);
    run_seq(b, 0);
    chk("R1 dropped write never queued", int'(rd_ctx), 0);
    ovf_clr = 1; step(); ovf_clr = 0;
    chk("R4 clear", int'(ovf_flag), 0);

    // R12: write in the consuming cycle while full
    wr(a); wr(b);
    pulse_trig();
    chk("R12 request", int'(conv_req), 1);
    conv_done = 1; wr_en = 1; wr_ctx = c[21:0];
    step();
    conv_done = 0; wr_en = 0;
    chk("R12 no overflow", int'(ovf_flag), 0);
    chk("R12 next active", int'(rd_ctx), b);
    run_seq(b, 0);
    chk("R12 write stored", int'(rd_ctx), c);
    run_seq(c, 0);
    chk("R12 drained", int'(rd_ctx), 0);

    // R8 flush mid-sequence in mode 1
    a = mk(2, 1, 2, 3, 0);
    wr(a); wr(b);
    pulse_trig();
    stop_req = 1; step(); stop_req = 0;
    chk("R8 mode1 flush empties", int'(rd_ctx), 0);
    chk("R8 position reset", int'(seq_pos), 0);
    pulse_done();
    chk("R8 no request after abort", int'(conv_req), 0);

    // R6/R8 mode 0
    qmode = 0;
    wr(a); wr(b);
    dis_req = 1; step(); dis_req = 0;
    chk("R8 mode0 keeps active", int'(rd_ctx), a);
    run_seq(a, 0);
    chk("R8 queued entry flushed", int'(rd_ctx), a);
    run_seq(a, 1);
    chk("R6 retained", int'(rd_ctx), a);
    wr(b);
    chk("R6 retained stays active", int'(rd_ctx), a);
    run_seq(a, 0);
    chk("R3 mode0 advance", int'(rd_ctx), b);
    run_seq(b, 0);
    chk("R6 last kept", int'(rd_ctx), b);
    run_seq(b, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule